// File: doc/BRIEF.md
# Synchronization Cell Window Decoder

This block holds the two 64-bit configuration words that place a window of synchronization cells in the address map and set its size. A simple register port reads and writes the words. From the first word the block derives a window base address and a window enable. From the second word it derives a window size and a cell spacing. These three window values are held in registers and update in the same clock edge that changes a configuration word.

The block also decodes a storage offset into two results. The first is a cell index, clamped to the last cell that exists. The second is a 4-bit view code that tells the cell logic downstream how an access is to be treated. The number of cells is set at elaboration as FIFO cells plus semaphore cells, with at most 16 of each. The cells themselves are not part of this block.

Top module: `cell_window_decoder`

## Requirements
- R1: During and after reset, word 0 reads 0 and word 1 reads 0xC00 with the cell count (FIFO_CELLS + SEM_CELLS) in bits 27:20. The window enable is 0, the base is 0 and the size is 4096.
- R2: When cfg_valid=1 and cfg_write=0, cfg_rdata returns the word at index cfg_addr>>3. Index 0 is word 0 and index 1 is word 1. Every other index returns 0. cfg_rdata is 0 when no read is requested.
- R3: A write (cfg_valid=1, cfg_write=1) to index 0 changes only bits 31:10 and bit 0. A write to index 1 changes only bits 16:10 and 2:0. All other bits keep their values. A write to any index other than 0 or 1 changes nothing.
- R4: win_base equals word 0 bits 31:10 with ten low zero bits, and win_en equals word 0 bit 0. Both are registered and follow a changing write on the next clock edge.
- R5: The candidate size is 1024 plus (word 1 AND 0x1FC00). It is loaded into win_size on the edge that changes a word, but only when the candidate is a power of two. Otherwise win_size keeps its previous value.
- R6: cell_idx equals st_ofs shifted right by 7 plus the grain field (word 1 bits 2:0). Any result at or above the cell count is replaced by the cell count minus 1.
- R7: view_code equals st_ofs bits 6:3, whatever the grain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Register access strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | REG_AW | Register byte address; bits above 2 select the word |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data (combinational) |
| st_ofs | input | OFS_W | Storage offset to decode |
| cell_idx | output | $clog2(FIFO_CELLS+SEM_CELLS) | Decoded, clamped cell index |
| view_code | output | 4 | Access view code |
| win_en | output | 1 | Window enable |
| win_base | output | 32 | Window base address |
| win_size | output | 18 | Window size in bytes |

## Verification
Offsets are swept under grain 0, 3 and 7. This separates the effect of the shift amount from the clamp, and it shows that the view bits do not depend on the grain. Writes put all ones, mixed patterns and unchanged values into both words, and also target indices that do not exist. Read-back then shows whether each protected bit kept its value. The mask field is set to values whose candidate size is a power of two and to values whose candidate is not. A size that is taken can then be told apart from a size that is held.

// File: rtl/cwd_pkg.sv
// Shared constants for the cell window decoder.
// Assumes 64-bit configuration words.
package cwd_pkg;
    localparam logic [63:0] W0_WMASK   = 64'h0000_0000_FFFF_FC01;
    localparam logic [63:0] W1_WMASK   = 64'h0000_0000_0001_FC07;
    localparam logic [63:0] W1_RST_LOW = 64'h0000_0000_0000_0FFF & 64'h0000_0000_0001_FC00;
    localparam int          CNT_LSB    = 20;
    localparam int          SIZE_W     = 18;
    localparam logic [SIZE_W-1:0] RST_SIZE = 18'd1024 + 18'h00C00;
endpackage

// File: rtl/cwd_cfg_regs.sv
// Configuration word pair with masked writes and read mux.
// Assumes cfg_addr bits 2:0 are zero (8-byte words); NCELLS < 256.
module cwd_cfg_regs
    import cwd_pkg::*;
#(
    parameter int NCELLS = 16,
    parameter int REG_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [63:0]       cfg_wdata,
    output logic [63:0]       cfg_rdata,
    output logic [2:0]        cur_grain,
    output logic [21:0]       nxt_base_f,
    output logic              nxt_en,
    output logic [6:0]        nxt_mask_f,
    output logic              upd
);
    localparam logic [63:0] W1_RST = W1_RST_LOW | (64'(NCELLS) << CNT_LSB);

    logic [REG_AW-1:0] idx;
    logic [63:0] word0, word1, nxt0, nxt1;
    logic wr0, wr1;

    // Word select from the byte address.
    assign idx = cfg_addr >> 3;

    // Masked merge of write data and change detection.
    always_comb begin
        wr0  = cfg_valid && cfg_write && (idx == '0);
        wr1  = cfg_valid && cfg_write && (idx == REG_AW'(1));
        nxt0 = wr0 ? ((cfg_wdata & W0_WMASK) | (word0 & ~W0_WMASK)) : word0;
        nxt1 = wr1 ? ((cfg_wdata & W1_WMASK) | (word1 & ~W1_WMASK)) : word1;
        upd  = (nxt0 != word0) || (nxt1 != word1);
    end

    // Word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word0 <= '0;
            word1 <= W1_RST;
        end else begin
            word0 <= nxt0;
            word1 <= nxt1;
        end
    end

    // Read mux; unmapped indices and idle cycles give zero.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_valid && !cfg_write) begin
            if (idx == '0)              cfg_rdata = word0;
            else if (idx == REG_AW'(1)) cfg_rdata = word1;
        end
    end

    assign cur_grain  = word1[2:0];
    assign nxt_base_f = nxt0[31:10];
    assign nxt_en     = nxt0[0];
    assign nxt_mask_f = nxt1[16:10];

    AST_W0_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (word0 & ~W0_WMASK) == '0);                                   // R3
    AST_W1_COUNT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        word1[27:20] == 8'(NCELLS));                                  // R3
endmodule

// File: rtl/cwd_window_calc.sv
// Registered window base, enable and size.
// Assumes upd marks the edge on which a configuration word changes.
module cwd_window_calc
    import cwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [21:0]       nxt_base_f,
    input  logic              nxt_en,
    input  logic [6:0]        nxt_mask_f,
    output logic              win_en,
    output logic [31:0]       win_base,
    output logic [SIZE_W-1:0] win_size
);
    logic [SIZE_W-1:0] cand;
    logic              is_pow2;

    // Candidate size and its power-of-two test.
    always_comb begin
        cand    = 18'd1024 + {1'b0, nxt_mask_f, 10'd0};
        is_pow2 = (cand & (cand - 18'd1)) == '0;
    end

    // Window registers, reloaded only on a real change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_en   <= 1'b0;
            win_base <= '0;
            win_size <= RST_SIZE;
        end else if (upd) begin
            win_en   <= nxt_en;
            win_base <= {nxt_base_f, 10'd0};
            if (is_pow2) win_size <= cand;
        end
    end

    AST_SIZE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(win_size) == 1);                                   // R5
    AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(win_size) && $stable(win_base) && $stable(win_en))); // R4
endmodule

// File: rtl/cwd_cell_decode.sv
// Storage offset to cell index and view code.
// Assumes OFS_W > 7 and NCELLS >= 2.
module cwd_cell_decode #(
    parameter int NCELLS = 16,
    parameter int OFS_W  = 17,
    parameter int CW     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       grain,
    input  logic [OFS_W-1:0] st_ofs,
    output logic [CW-1:0]    cell_idx,
    output logic [3:0]       view_code
);
    logic [3:0]       shift;
    logic [OFS_W-1:0] raw;

    // Shift by spacing, then clamp to the last cell.
    always_comb begin
        shift    = 4'd7 + {1'b0, grain};
        raw      = st_ofs >> shift;
        cell_idx = (raw >= OFS_W'(NCELLS)) ? CW'(NCELLS - 1) : raw[CW-1:0];
    end

    // View field.
    assign view_code = st_ofs[6:3];

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cell_idx) < NCELLS);                                      // R6
endmodule

// File: rtl/cell_window_decoder.sv
// Top: configuration words, window registers and cell decode.
// Assumes FIFO_CELLS <= 16, SEM_CELLS <= 16, and at least two cells in total.
module cell_window_decoder #(
    parameter int FIFO_CELLS = 12,
    parameter int SEM_CELLS  = 4,
    parameter int REG_AW     = 6,
    parameter int OFS_W      = 17,
    localparam int NCELLS    = FIFO_CELLS + SEM_CELLS,
    localparam int CW        = $clog2(NCELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [63:0]       cfg_wdata,
    output logic [63:0]       cfg_rdata,
    input  logic [OFS_W-1:0]  st_ofs,
    output logic [CW-1:0]     cell_idx,
    output logic [3:0]        view_code,
    output logic              win_en,
    output logic [31:0]       win_base,
    output logic [17:0]       win_size
);
    generate
        if (FIFO_CELLS > 16 || SEM_CELLS > 16 || NCELLS < 2) begin : g_bad_cfg
            $error("cell_window_decoder: cell counts out of range");
        end
    endgenerate

    logic [2:0]  grain;
    logic [21:0] nxt_base_f;
    logic        nxt_en;
    logic [6:0]  nxt_mask_f;
    logic        upd;

    cwd_cfg_regs #(.NCELLS(NCELLS), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cur_grain(grain), .nxt_base_f(nxt_base_f), .nxt_en(nxt_en),
        .nxt_mask_f(nxt_mask_f), .upd(upd)
    );

    cwd_window_calc u_calc (
        .clk(clk), .rst_n(rst_n), .upd(upd), .nxt_base_f(nxt_base_f),
        .nxt_en(nxt_en), .nxt_mask_f(nxt_mask_f),
        .win_en(win_en), .win_base(win_base), .win_size(win_size)
    );

    cwd_cell_decode #(.NCELLS(NCELLS), .OFS_W(OFS_W), .CW(CW)) u_dec (
        .clk(clk), .rst_n(rst_n), .grain(grain), .st_ofs(st_ofs),
        .cell_idx(cell_idx), .view_code(view_code)
    );
endmodule

// File: tb/cell_window_decoder_bench.sv
module cell_window_decoder_bench;
    localparam int NC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_valid = 1'b0, cfg_write = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic [16:0] st_ofs = '0;
    logic [3:0]  cell_idx;
    logic [3:0]  view_code;
    logic        win_en;
    logic [31:0] win_base;
    logic [17:0] win_size;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    longint unsigned m0, m1, m_base, m_size;
    bit m_en;

    always #10 clk = ~clk;

    cell_window_decoder u_cell_window_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .st_ofs(st_ofs), .cell_idx(cell_idx), .view_code(view_code),
        .win_en(win_en), .win_base(win_base), .win_size(win_size)
    );

    task automatic chk(string tag, string what, longint unsigned act, longint unsigned exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m0 = 0;
        m1 = 64'hC00 | (longint'(NC) << 20);
        m_base = 0; m_size = 4096; m_en = 1'b0;
    endtask

    // One clock: drive, compare every output, then advance the model.
    task automatic step(string tag, bit v, bit w, int a, longint unsigned d, int ofs);
        longint unsigned rd, n, s;
        int idx, g, r;
        bit chg;
        @(negedge clk);
        cfg_valid = v; cfg_write = w; cfg_addr = 6'(a); cfg_wdata = d; st_ofs = 17'(ofs);
        #5;
        idx = a / 8;
        rd = 0;
        if (v && !w) rd = (idx == 0) ? m0 : (idx == 1) ? m1 : 0;
        g = int'(m1 % 8);
        r = ofs / (1 << (7 + g));
        if (r >= NC) r = NC - 1;
        chk({tag, "/R2"}, "cfg_rdata", cfg_rdata, rd);
        chk({tag, "/R6"}, "cell_idx", longint'(cell_idx), longint'(r));
        chk({tag, "/R7"}, "view_code", longint'(view_code), longint'((ofs / 8) % 16));
        chk({tag, "/R4"}, "win_en", longint'(win_en), longint'(m_en));
        chk({tag, "/R4"}, "win_base", longint'(win_base), m_base);
        chk({tag, "/R5"}, "win_size", longint'(win_size), m_size);
        @(posedge clk);
        if (rst_n && v && w && (idx == 0 || idx == 1)) begin
            chg = 1'b0;
            if (idx == 0) begin
                n = (d & 64'hFFFFFC01) | (m0 & ~64'hFFFFFC01);
                chg = (n != m0); m0 = n;
            end else begin
                n = (d & 64'h1FC07) | (m1 & ~64'h1FC07);
                chg = (n != m1); m1 = n;
            end
            if (chg) begin
                m_base = (m0 / 1024 % (1 << 22)) * 1024;
                m_en   = m0[0];
                s = 1024 + (m1 & 64'h1FC00);
                if ((s & (s - 1)) == 0) m_size = s;
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(posedge clk); @(posedge clk);
        // R1: reset values, read both words while reset is held
        step("R1", 1, 0, 0, 0, 0);
        step("R1", 1, 0, 8, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        step("R1", 1, 0, 8, 0, 300);
        // R2: unmapped indices read zero, idle read zero
        step("R2", 1, 0, 16, 0, 0);
        step("R2", 1, 0, 40, 0, 0);
        step("R2", 0, 0, 0, 0, 0);
        // R3/R4: all-ones write to word 0 keeps reserved bits zero
        step("R3", 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        step("R3", 1, 0, 0, 0, 0);
        step("R4", 1, 1, 0, 64'h0000_0000_1234_5400, 0);
        step("R4", 1, 0, 0, 0, 0);
        step("R4", 1, 1, 0, 64'h0000_0000_1234_5400, 0);   // unchanged value
        // R3: writes to missing indices change nothing
        step("R3", 1, 1, 16, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        step("R3", 1, 1, 56, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        step("R3", 1, 0, 0, 0, 0);
        step("R3", 1, 0, 8, 0, 0);
        // R5: non-power-of-two candidate is held, then a valid one is taken
        step("R5", 1, 1, 8, 64'hFFFF_FFFF_FFF0_1400, 0);
        step("R5", 1, 0, 8, 0, 0);
        step("R5", 1, 1, 8, 64'h0000_0000_0000_1C00, 0);
        step("R5", 1, 1, 8, 64'h0000_0000_0001_FC00, 0);
        step("R5", 1, 1, 8, 64'h0000_0000_0000_0000, 0);
        step("R5", 1, 1, 8, 64'h0000_0000_0000_0800, 0);
        // R6/R7: grain 0 sweep, including clamp above 16 cells
        for (int o = 0; o < 4096; o += 200) step("R6", 0, 0, 0, 0, o);
        step("R6", 0, 0, 0, 0, 131071);
        // R6/R7: grain 3 and grain 7
        step("R6", 1, 1, 8, 64'h0000_0000_0000_0C03, 0);
        for (int o = 0; o < 131072; o += 3001) step("R6", 0, 0, 0, 0, o);
        step("R6", 1, 1, 8, 64'h0000_0000_0000_0C07, 0);
        for (int o = 0; o < 131072; o += 7777) step("R7", 0, 0, 0, 0, o);
        step("R7", 1, 0, 8, 0, 120);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule